// File: doc/BRIEF.md
# Shared-Bus Arbiter with Bounded Host Wait

This block decides which agent owns a shared bus. Several peripheral masters and one host port raise request lines. The block answers with exactly one registered grant, or with none. A grant is held until the bus reports the end of the transfer with a one-cycle completion pulse. At that point, or whenever the bus has no owner, the block picks the next owner.

Peripheral masters take turns round-robin. The host is not simply given top priority. Once it asks for the bus, it is promised a grant within a bounded number of peripheral transfers. A 2-bit wait setting selects 1, 2 or 3. A small setting keeps host latency low. A larger setting gives the peripherals more of the bus. If no peripheral is asking, the host does not wait at all.

All pins are plain level or pulse controls. The block carries no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `arb_host_bounded`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, every grant output is low.
- R2: At most one of the peripheral grants and the host grant is high in any cycle.
- R3: While a grant is active, the grant outputs do not change except on the clock edge that samples `xfer_done` high.
- R4: If the bus is unowned and any request is high, a grant is asserted on the next clock edge. If `xfer_done` is sampled while no request is high, all grants are low after that edge.
- R5: Peripheral masters are served round-robin. The search starts at the master after the one granted last, so after reset master 0 is first. For example, with requests 4'b1011 held, the order is 0, 1, 3, 0.
- R6: The wait setting `wait_sel` is decoded as 2'd1 → 1 and 2'd0 → 1. With a limit of 1, a pending host request is granted on the edge that ends the peripheral transfer in progress.
- R7: With `wait_sel` = 2'd2, a pending host is granted on the edge that ends the second peripheral transfer completed while it waits.
- R8: With `wait_sel` = 2'd3, a pending host is granted on the edge that ends the third such transfer. The bound holds whichever masters are queued and whenever the host raised its request.
- R9: If no peripheral request is high at an arbitration point, a pending host request is granted at that point with no wait.
- R10: A host transfer uses one slot of the rotation. If the host keeps its request high, its peripheral count restarts from zero after the host transfer ends.
- R11: Peripheral transfers count toward the host's wait only if they complete while the host request is high.
- R12: A `xfer_done` pulse while the bus is unowned has no effect on the grants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| per_req | input | N_PERIPH | Peripheral master request lines |
| per_gnt | output | N_PERIPH | Peripheral master grant lines, registered |
| host_req | input | 1 | Host request |
| host_gnt | output | 1 | Host grant, registered |
| xfer_done | input | 1 | One-cycle pulse marking the end of the current bus transfer |
| wait_sel | input | 2 | Maximum number of peripheral transfers the host waits (0 and 1 both mean 1) |

## Verification
Some properties are checked on every cycle:
- At most one grant is high.
- A grant is held between completion pulses.
- An unowned bus with a request is granted on the next edge.
- A new grant goes only to an agent that was requesting.
- A shadow counter of peripheral transfers completed while the host waits never exceeds the selected limit.

Other behaviours need the bench's scenarios to show them:
- The exact round-robin order.
- That the host is granted exactly at the limit and not earlier.
- That transfers finished before the host request are not counted.
- That the count restarts after a host transfer.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Largest host wait the 2-bit setting can select.
  localparam int unsigned MAX_WAIT = 3;
  localparam int unsigned WAIT_W   = $clog2(MAX_WAIT + 1);

  // Decode the setting; zero is treated like one.
  function automatic logic [WAIT_W-1:0] wait_limit(input logic [1:0] sel);
    logic [WAIT_W-1:0] lim;
    case (sel)
      2'd2:    lim = WAIT_W'(2);
      2'd3:    lim = WAIT_W'(3);
      default: lim = WAIT_W'(1);
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int unsigned N_PERIPH = 4,
  localparam int unsigned IDX_W   = (N_PERIPH > 1) ? $clog2(N_PERIPH) : 1
) (
  input  logic [N_PERIPH-1:0] req,
  input  logic [IDX_W-1:0]    last_idx,
  output logic                found,
  output logic [IDX_W-1:0]    pick_idx
);

  // Rotate the request vector so that bit k is the master k places after last_idx.
  logic [N_PERIPH-1:0] rot_req;

  for (genvar k = 0; k < N_PERIPH; k++) begin : g_rot
    always_comb begin
      int unsigned src;
      src = (int'(last_idx) + k + 1) % N_PERIPH;
      rot_req[k] = req[src];
    end
  end

  // Search from the farthest slot to the nearest, so the nearest requester is the one kept.
  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    for (int k = N_PERIPH - 1; k >= 0; k--) begin
      if (rot_req[k]) begin
        found    = 1'b1;
        pick_idx = IDX_W'((int'(last_idx) + k + 1) % N_PERIPH);
      end
    end
  end

endmodule

// File: rtl/arb_host_wait.sv
module arb_host_wait
  import arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              periph_done,
  input  logic              host_win,
  input  logic [WAIT_W-1:0] limit,
  output logic              quota_met
);

  logic [WAIT_W-1:0] cnt_q;
  logic [WAIT_W-1:0] cnt_eff;

  // The transfer ending in this cycle already counts toward the quota.
  always_comb begin
    cnt_eff = cnt_q;
    if (periph_done && host_req && (cnt_q != WAIT_W'(MAX_WAIT)))
      cnt_eff = cnt_q + WAIT_W'(1);
  end

  assign quota_met = (cnt_eff >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!host_req || host_win)
      cnt_q <= '0;
    else
      cnt_q <= cnt_eff;
  end

endmodule

// File: rtl/arb_grant_reg.sv
module arb_grant_reg #(
  parameter int unsigned N_PERIPH = 4,
  localparam int unsigned IDX_W   = (N_PERIPH > 1) ? $clog2(N_PERIPH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                advance,
  input  logic                sel_host,
  input  logic                sel_periph,
  input  logic [IDX_W-1:0]    pick_idx,
  output logic [N_PERIPH-1:0] per_gnt,
  output logic                host_gnt,
  output logic [IDX_W-1:0]    last_idx
);

  logic [N_PERIPH-1:0] pick_onehot;

  for (genvar m = 0; m < N_PERIPH; m++) begin : g_dec
    assign pick_onehot[m] = sel_periph && (pick_idx == IDX_W'(m));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_gnt  <= '0;
      host_gnt <= 1'b0;
      last_idx <= IDX_W'(N_PERIPH - 1);
    end else if (advance) begin
      per_gnt  <= pick_onehot;
      host_gnt <= sel_host;
      if (sel_periph)
        last_idx <= pick_idx;
    end
  end

endmodule

// File: rtl/arb_host_bounded.sv
module arb_host_bounded
  import arb_pkg::*;
#(
  parameter int unsigned N_PERIPH = 4,
  localparam int unsigned IDX_W   = (N_PERIPH > 1) ? $clog2(N_PERIPH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_PERIPH-1:0] per_req,
  output logic [N_PERIPH-1:0] per_gnt,
  input  logic                host_req,
  output logic                host_gnt,
  input  logic                xfer_done,
  input  logic [1:0]          wait_sel
);

  logic              busy;
  logic              advance;
  logic              periph_done;
  logic              quota_met;
  logic              found;
  logic [IDX_W-1:0]  pick_idx;
  logic [IDX_W-1:0]  last_idx;
  logic              sel_host;
  logic              sel_periph;
  logic [WAIT_W-1:0] limit;

  assign busy        = host_gnt || (|per_gnt);
  assign advance     = !busy || xfer_done;
  assign periph_done = xfer_done && (|per_gnt);
  assign limit       = wait_limit(wait_sel);

  arb_rr_pick #(.N_PERIPH(N_PERIPH)) u_pick (
    .req      (per_req),
    .last_idx (last_idx),
    .found    (found),
    .pick_idx (pick_idx)
  );

  arb_host_wait u_wait (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (host_req),
    .periph_done (periph_done),
    .host_win    (sel_host),
    .limit       (limit),
    .quota_met   (quota_met)
  );

  // The host wins once its quota is met, or at once if no peripheral is asking.
  assign sel_host   = advance && host_req && (quota_met || !(|per_req));
  assign sel_periph = advance && !sel_host && found;

  arb_grant_reg #(.N_PERIPH(N_PERIPH)) u_gnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .advance    (advance),
    .sel_host   (sel_host),
    .sel_periph (sel_periph),
    .pick_idx   (pick_idx),
    .per_gnt    (per_gnt),
    .host_gnt   (host_gnt),
    .last_idx   (last_idx)
  );

endmodule

// File: rtl/arb_host_bounded_chk.sv
module arb_host_bounded_chk #(
  parameter int unsigned N_PERIPH = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_PERIPH-1:0] per_req,
  input logic [N_PERIPH-1:0] per_gnt,
  input logic                host_req,
  input logic                host_gnt,
  input logic                xfer_done,
  input logic [1:0]          wait_sel
);

  logic       busy;
  logic [2:0] shadow_cnt;
  logic [2:0] shadow_lim;

  assign busy       = host_gnt || (|per_gnt);
  assign shadow_lim = (wait_sel == 2'd0) ? 3'd1 : {1'b0, wait_sel};

  // Independent count of peripheral transfers completed while the host waits.
  always_ff @(posedge clk) begin
    if (!rst_n || host_gnt || !host_req)
      shadow_cnt <= '0;
    else if (xfer_done && (|per_gnt) && (shadow_cnt != 3'd7))
      shadow_cnt <= shadow_cnt + 3'd1;
  end

  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({per_gnt, host_gnt}));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done) |=> $stable({per_gnt, host_gnt}));

  p_idle_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ((|per_req) || host_req)) |=> busy);

  p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !(|per_req) && !host_req) |=> !busy);

  p_gnt_to_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((per_gnt != $past(per_gnt)) && (|per_gnt)) |-> ((per_gnt & $past(per_req)) == per_gnt));

  p_host_from_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_gnt) |-> $past(host_req));

  // Covers R6, R7 and R8.
  p_host_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_cnt <= shadow_lim);

endmodule

bind arb_host_bounded arb_host_bounded_chk #(.N_PERIPH(N_PERIPH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .per_req   (per_req),
  .per_gnt   (per_gnt),
  .host_req  (host_req),
  .host_gnt  (host_gnt),
  .xfer_done (xfer_done),
  .wait_sel  (wait_sel)
);

// File: tb/test_arb_host_bounded.sv
module test_arb_host_bounded;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] per_req = '0;
  logic [N-1:0] per_gnt;
  logic         host_req = 1'b0;
  logic         host_gnt;
  logic         xfer_done = 1'b0;
  logic [1:0]   wait_sel = 2'd1;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  arb_host_bounded #(.N_PERIPH(N)) i_arb_host_bounded (
    .clk(clk), .rst_n(rst_n), .per_req(per_req), .per_gnt(per_gnt),
    .host_req(host_req), .host_gnt(host_gnt), .xfer_done(xfer_done),
    .wait_sel(wait_sel)
  );

  // Vector fields: [9:8] wait setting, [7:4] peripheral requests, [3:0] expected waits.
  localparam logic [9:0] VEC [8] = '{
    {2'd1, 4'b1111, 4'd1},
    {2'd2, 4'b1111, 4'd2},
    {2'd3, 4'b1111, 4'd3},
    {2'd0, 4'b1111, 4'd1},
    {2'd3, 4'b0001, 4'd3},
    {2'd2, 4'b0100, 4'd2},
    {2'd3, 4'b0000, 4'd0},
    {2'd1, 4'b0000, 4'd0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_done();
    @(negedge clk) xfer_done = 1'b1;
    @(negedge clk) xfer_done = 1'b0;
  endtask

  task automatic drain();
    per_req  = '0;
    host_req = 1'b0;
    pulse_done();
  endtask

  // Count peripheral transfers until the host is granted.
  task automatic count_to_host(output int n);
    n = 0;
    for (int g = 0; g < 40; g++) begin
      if (host_gnt) break;
      if (|per_gnt) begin
        pulse_done();
        n++;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  initial begin
    #2_000_000ns;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(per_gnt == 0 && host_gnt == 0, "R1 in reset", {per_gnt, host_gnt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(per_gnt == 0 && host_gnt == 0, "R1 after reset", {per_gnt, host_gnt}, 0);

    // R5: round-robin order with requests 1011, starting at master 0.
    per_req = 4'b1011;
    @(negedge clk);
    check(per_gnt == 4'b0001, "R5 first", per_gnt, 1);
    // R3: held without a completion pulse.
    repeat (3) @(negedge clk);
    check(per_gnt == 4'b0001, "R3 hold", per_gnt, 1);
    pulse_done();
    check(per_gnt == 4'b0010, "R5 second", per_gnt, 2);
    pulse_done();
    check(per_gnt == 4'b1000, "R5 third", per_gnt, 8);
    pulse_done();
    check(per_gnt == 4'b0001, "R5 wrap", per_gnt, 1);

    // R4: done with no requesters drops the grant.
    drain();
    check(per_gnt == 0 && host_gnt == 0, "R4 drop", {per_gnt, host_gnt}, 0);

    // R12: done while idle changes nothing.
    pulse_done();
    check(per_gnt == 0 && host_gnt == 0, "R12 idle done", {per_gnt, host_gnt}, 0);

    // R4: an idle bus grants on the next edge.
    per_req = 4'b0100;
    @(negedge clk);
    check(per_gnt == 4'b0100, "R4 idle grant", per_gnt, 4);

    // Table walk: R6, R7, R8 and R9.
    foreach (VEC[i]) begin
      drain();
      wait_sel = VEC[i][9:8];
      per_req  = VEC[i][7:4];
      @(negedge clk);
      host_req = 1'b1;
      count_to_host(n);
      check(host_gnt && per_gnt == 0, "R6/R7/R8/R9 host granted", host_gnt, 1);
      check(n == int'(VEC[i][3:0]), "R6/R7/R8/R9 wait count", n, int'(VEC[i][3:0]));
    end

    // R11: transfers finished before the host asks do not count.
    drain();
    wait_sel = 2'd2;
    per_req  = 4'b1111;
    @(negedge clk);
    pulse_done();
    pulse_done();
    host_req = 1'b1;
    count_to_host(n);
    check(n == 2, "R11 early transfers ignored", n, 2);

    // R10: the host transfer takes one slot, then the count restarts.
    pulse_done();
    check(host_gnt == 0 && per_gnt != 0, "R10 peripheral after host", per_gnt, 1);
    count_to_host(n);
    check(n == 2, "R10 count restarted", n, 2);

    drain();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule